// File: doc/BRIEF.md
# Forward Euler Multi-Scroll Chaotic Oscillator Core

This core integrates a third-order jerk system, x' = y, y' = z, z' = −a·x − b·y − c·z + d·f(x), one forward Euler step at a time. It uses signed fixed-point words of 28 bits (three integer bits and 24 fraction bits). The nonlinearity f(x) is a series of saturated ramps. The number of ramps is set at elaboration, and that count fixes how many scrolls the attractor shows. Every constant product (time step, coefficients, ramp slope) comes from a shift-and-add network that the constant itself selects. No general multiplier is used.

After reset, the core builds its first step from three initial-condition inputs. A step counter keeps those inputs in the loop for the first step. After that first update it switches the loop multiplexer to the registered state, and from then on the core runs freely. The z path holds one internal pipeline register. The state registers therefore load x, y and z together only on the last cycle of each step window. That load is flagged by a one-cycle valid pulse.

Top module: `chaos_euler_core`

## Requirements
- R1: While rst_ni is low, x_o, y_o and z_o are zero and valid_o is low.
- R2: After reset is released, valid_o stays low for STEP_CYC−1 cycles. In the STEP_CYC-th cycle it goes high, and the outputs hold one Euler step computed from x_init_i, y_init_i and z_init_i.
- R3: After the first step, valid_o pulses for one cycle every STEP_CYC cycles, and each step starts from the core's own previous state. Changes on the initial-condition inputs then have no effect.
- R4: x_next = sat(x + K(y, DT)).
- R5: y_next = sat(y + K(z, DT)).
- R6: z_next = sat(z + K(g, DT)), where g = sat(−K(x,A) − K(y,B) − K(z,C) + K(f(x),D)), and the four terms are summed at full width.
- R7: A constant product K(v, k) is the exact product v·k (k being the constant scaled by 2^24), shifted right arithmetically by 24 bits. A negative product therefore rounds toward minus infinity.
- R8: f(x) is the sum, for i = 0..SCROLLS−2, of one ramp term at centre h = (2i − SCROLLS + 2)·HSTEP. Let e = x − h. The term is 1 + s when e > M, s − 1 when e < −M, and K(e, INV_M) + s otherwise. Here s is +1, 0 or −1 according to the sign of h.
- R9: Every sum that is marked sat clamps to [−2^27, 2^27 − 1] instead of wrapping.
- R10: Between valid pulses, x_o, y_o and z_o do not change.
- R11: All words are two's-complement, 28 bits wide, with 24 fraction bits, so the value 1.0 is 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_init_i | input | 28 | Initial x, used for the first step only |
| y_init_i | input | 28 | Initial y, used for the first step only |
| z_init_i | input | 28 | Initial z, used for the first step only |
| x_o | output | 28 | State x |
| y_o | output | 28 | State y |
| z_o | output | 28 | State z |
| valid_o | output | 1 | One-cycle pulse marking a new state |

## Verification
The bench builds the core with STEP_CYC = 6 and SCROLLS = 3. With three scrolls there are two ramp centres, at ±1.0, with nonzero plateau offsets. Initial conditions placed exactly on and just past those breakpoints then select every branch of f. The shorter step window keeps a several-hundred-step free run and many reset-and-restart cases inside a short run. Initial values at the format extremes drive the x, y and derivative sums into clamping.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int OSC_W    = 28;
  localparam int OSC_FRAC = 24;
  localparam int Q_ONE    = 1 << OSC_FRAC;
  localparam int K_DT     = 167772;      // 0.01
  localparam int K_COEF   = 11744051;    // 0.7
  localparam int K_INV_M  = 1016800970;  // 1/0.0165
  localparam int K_M      = 276824;      // 0.0165
endpackage

// File: rtl/osc_const_mult.sv
module osc_const_mult #(
  parameter int IW   = 28,
  parameter int OW   = 28,
  parameter int FRAC = 24,
  parameter int K    = 0
) (
  input  logic signed [IW-1:0] a_i,
  output logic signed [OW-1:0] p_o
);
  localparam int PW = IW + 33;
  localparam logic [31:0] KMAG = (K < 0) ? 32'(-K) : 32'(K);

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] pp [32];
  logic signed [PW-1:0] acc;

  assign a_ext = PW'(a_i);

  // one shifted copy per set bit of the constant
  for (genvar i = 0; i < 32; i++) begin : g_pp
    if (KMAG[i]) begin : g_on
      assign pp[i] = a_ext <<< i;
    end else begin : g_off
      assign pp[i] = '0;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < 32; i++) acc = acc + pp[i];
    if (K < 0) acc = -acc;
  end

  assign p_o = OW'(acc >>> FRAC);
endmodule

// File: rtl/osc_sat_series.sv
module osc_sat_series #(
  parameter int W       = 28,
  parameter int FRAC    = 24,
  parameter int SCROLLS = 2,
  parameter int HSTEP   = 1 << 24,
  parameter int M       = 276824,
  parameter int INV_M   = 1016800970
) (
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] f_o
);
  localparam int NT  = SCROLLS - 1;
  localparam int DW  = W + 4;
  localparam int ONE = 1 << FRAC;

  logic [NT:0][DW-1:0] acc;
  assign acc[0] = '0;

  for (genvar i = 0; i < NT; i++) begin : g_seg
    localparam int H   = (2*i - SCROLLS + 2) * HSTEP;
    localparam int OFS = (H > 0) ? ONE : ((H < 0) ? -ONE : 0);
    logic signed [DW-1:0] dlt;
    logic signed [DW-1:0] slope;
    logic signed [DW-1:0] term;

    assign dlt = DW'(x_i) - DW'(H);

    osc_const_mult #(.IW(DW), .OW(DW), .FRAC(FRAC), .K(INV_M)) u_slope (
      .a_i(dlt),
      .p_o(slope)
    );

    always_comb begin
      if (dlt > DW'(M))       term = DW'(ONE + OFS);
      else if (dlt < -DW'(M)) term = DW'(OFS - ONE);
      else                    term = slope + DW'(OFS);
    end

    assign acc[i+1] = acc[i] + term;
  end

  assign f_o = W'(acc[NT]);
endmodule

// File: rtl/osc_step_seq.sv
module osc_step_seq #(
  parameter int STEP_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fb_sel_o,
  output logic update_o
);
  localparam int CW = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          fb_q;

  assign update_o = (cnt_q == CW'(STEP_CYC - 1));
  assign fb_sel_o = fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fb_q  <= 1'b0;
    end else begin
      cnt_q <= update_o ? '0 : cnt_q + 1'b1;
      if (update_o) fb_q <= 1'b1;
    end
  end
endmodule

// File: rtl/chaos_euler_core.sv
module chaos_euler_core
  import osc_pkg::*;
#(
  parameter int W        = OSC_W,
  parameter int FRAC     = OSC_FRAC,
  parameter int STEP_CYC = 8,    // >= 2, z path has one register
  parameter int SCROLLS  = 2,    // 2..8
  parameter int DT       = K_DT,
  parameter int COEF_A   = K_COEF,
  parameter int COEF_B   = K_COEF,
  parameter int COEF_C   = K_COEF,
  parameter int COEF_D   = K_COEF,
  parameter int HSTEP    = Q_ONE,
  parameter int M        = K_M,
  parameter int INV_M    = K_INV_M
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] x_init_i,
  input  logic signed [W-1:0] y_init_i,
  input  logic signed [W-1:0] z_init_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o,
  output logic                valid_o
);
  localparam int SW = W + 4;
  localparam logic signed [SW-1:0] SMAX = SW'((longint'(1) <<< (W-1)) - 1);
  localparam logic signed [SW-1:0] SMIN = -SMAX - SW'(1);

  function automatic logic signed [W-1:0] sat_w(input logic signed [SW-1:0] v);
    if (v > SMAX)      return SMAX[W-1:0];
    else if (v < SMIN) return SMIN[W-1:0];
    else               return v[W-1:0];
  endfunction

  logic fb_sel, update;
  logic signed [W-1:0] x_q, y_q, z_q, deriv_q;
  logic signed [W-1:0] xs, ys, zs;
  logic signed [W-1:0] dx, dy, dz, ax, by, cz, df, fx;
  logic signed [W-1:0] deriv_d, x_n, y_n, z_n;
  logic valid_q;

  osc_step_seq #(.STEP_CYC(STEP_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fb_sel_o(fb_sel),
    .update_o(update)
  );

  // loop multiplexer: initial conditions until the first update
  assign xs = fb_sel ? x_q : x_init_i;
  assign ys = fb_sel ? y_q : y_init_i;
  assign zs = fb_sel ? z_q : z_init_i;

  osc_sat_series #(
    .W(W), .FRAC(FRAC), .SCROLLS(SCROLLS), .HSTEP(HSTEP), .M(M), .INV_M(INV_M)
  ) u_fx (.x_i(xs), .f_o(fx));

  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(DT))     u_dx (.a_i(ys),      .p_o(dx));
  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(DT))     u_dy (.a_i(zs),      .p_o(dy));
  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(COEF_A)) u_ax (.a_i(xs),      .p_o(ax));
  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(COEF_B)) u_by (.a_i(ys),      .p_o(by));
  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(COEF_C)) u_cz (.a_i(zs),      .p_o(cz));
  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(COEF_D)) u_df (.a_i(fx),      .p_o(df));
  osc_const_mult #(.IW(W), .OW(W), .FRAC(FRAC), .K(DT))     u_dz (.a_i(deriv_q), .p_o(dz));

  assign deriv_d = sat_w(-SW'(ax) - SW'(by) - SW'(cz) + SW'(df));
  assign x_n     = sat_w(SW'(xs) + SW'(dx));
  assign y_n     = sat_w(SW'(ys) + SW'(dy));
  assign z_n     = sat_w(SW'(zs) + SW'(dz));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deriv_q <= '0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      deriv_q <= deriv_d;
      valid_q <= update;
      if (update) begin
        x_q <= x_n;
        y_q <= y_n;
        z_q <= z_n;
      end
    end
  end

  assign x_o     = x_q;
  assign y_o     = y_q;
  assign z_o     = z_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/chaos_euler_checker.sv
module chaos_euler_checker #(
  parameter int W        = 28,
  parameter int STEP_CYC = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic signed [W-1:0] x_o,
  input logic signed [W-1:0] y_o,
  input logic signed [W-1:0] z_o,
  input logic                valid_o
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= valid_o ? 32'd1 : gap_q + 32'd1;
      seen_q <= seen_q | valid_o;
    end
  end

  AST_STEP_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> gap_q == 32'(STEP_CYC)); // R3

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({x_o, y_o, z_o})); // R10

  AST_X_FOLLOWS_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q && !$past(y_o[W-1])) |-> $signed(x_o) >= $signed($past(x_o))); // R4

  AST_Y_FOLLOWS_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q && !$past(z_o[W-1])) |-> $signed(y_o) >= $signed($past(y_o))); // R5
endmodule

bind chaos_euler_core chaos_euler_checker #(.W(W), .STEP_CYC(STEP_CYC)) u_chk (.*);

// File: tb/tb_chaos_euler_core.sv
module tb_chaos_euler_core;
  localparam int  W     = 28;
  localparam int  STEP  = 6;
  localparam int  S     = 3;
  localparam longint ONE   = 64'd1 << 24;
  localparam longint DT    = 167772;
  localparam longint KC    = 11744051;
  localparam longint INVM  = 1016800970;
  localparam longint MB    = 276824;
  localparam longint QMAX  = (64'd1 << 27) - 1;
  localparam longint QMIN  = -(64'd1 << 27);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [W-1:0] xi, yi, zi;
  logic signed [W-1:0] xo, yo, zo;
  logic valid;

  int n_cmp = 0;
  int n_bad = 0;
  longint mx, my, mz;

  always #5 clk = ~clk;

  chaos_euler_core #(.STEP_CYC(STEP), .SCROLLS(S)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .x_init_i(xi), .y_init_i(yi), .z_init_i(zi),
    .x_o(xo), .y_o(yo), .z_o(zo), .valid_o(valid)
  );

  function automatic longint kmul(longint v, longint k);
    return (v * k) >>> 24;
  endfunction

  function automatic longint sat(longint v);
    if (v > QMAX) return QMAX;
    if (v < QMIN) return QMIN;
    return v;
  endfunction

  function automatic longint fser(longint x);
    longint acc = 0;
    for (int i = 0; i < S - 1; i++) begin
      longint h = longint'(2*i - S + 2) * ONE;
      longint dl = x - h;
      longint ofs = (h > 0) ? ONE : ((h < 0) ? -ONE : 0);
      if (dl > MB)       acc += ONE + ofs;
      else if (dl < -MB) acc += ofs - ONE;
      else               acc += kmul(dl, INVM) + ofs;
    end
    return acc;
  endfunction

  task automatic model_step();
    longint g, nx, ny;
    g  = sat(-kmul(mx, KC) - kmul(my, KC) - kmul(mz, KC) + kmul(fser(mx), KC));
    nx = sat(mx + kmul(my, DT));
    ny = sat(my + kmul(mz, DT));
    mz = sat(mz + kmul(g, DT));
    mx = nx;
    my = ny;
  endtask

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    check({tag, " R4 x"}, longint'(xo), mx);
    check({tag, " R5 y"}, longint'(yo), my);
    check({tag, " R6 z"}, longint'(zo), mz);
  endtask

  task automatic first_step(longint x0, longint y0, longint z0, string tag);
    rst_n = 1'b0;
    xi = W'(x0); yi = W'(y0); zi = W'(z0);
    mx = x0; my = y0; mz = z0;
    repeat (2) @(negedge clk);
    check("R1 reset x", longint'(xo), 0);
    check("R1 reset valid", longint'(valid), 0);
    rst_n = 1'b1;
    for (int k = 1; k < STEP; k++) begin
      @(negedge clk);
      if (valid) check("R2 early valid", 1, 0);
    end
    @(negedge clk);
    check("R2 first valid", longint'(valid), 1);
    model_step();
    check_state(tag);
  endtask

  task automatic next_step(string tag, bit scramble);
    longint hx = longint'(xo), hy = longint'(yo), hz = longint'(zo);
    for (int k = 1; k < STEP; k++) begin
      if (scramble) begin
        xi = W'($urandom); yi = W'($urandom); zi = W'($urandom);
      end
      @(negedge clk);
      if (valid) check("R3 valid spacing", 1, 0);
      if (longint'(xo) != hx || longint'(yo) != hy || longint'(zo) != hz)
        check("R10 hold", 1, 0);
    end
    @(negedge clk);
    check("R3 periodic valid", longint'(valid), 1);
    model_step();
    check_state(tag);
  endtask

  function automatic longint rnd_q();
    logic signed [W-1:0] r;
    r = W'($urandom);
    return longint'(r);
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    xi = '0; yi = '0; zi = '0;
    // default start, long free run with init inputs scrambled (R3)
    first_step(1677722, 1677722, 0, "R2 default");
    for (int s = 0; s < 300; s++) next_step("R3 feedback", 1'b1);
    // R7 floor of negative product
    first_step(0, -1, 0, "R7 floor");
    // R11 one is 2^24
    first_step(ONE, ONE, -ONE, "R11 unit");
    // R8 breakpoints around +1 and -1
    first_step(ONE + MB, 0, 0, "R8 edge+");
    first_step(ONE + MB + 1, 0, 0, "R8 plateau+");
    first_step(ONE - MB - 1, 0, 0, "R8 below+");
    first_step(-ONE - MB, 0, 0, "R8 edge-");
    first_step(-ONE - MB - 1, 0, 0, "R8 plateau-");
    first_step(-ONE + MB / 2, 0, 0, "R8 ramp-");
    // R9 clamping at both limits
    first_step(QMAX - 10, QMAX, QMAX, "R9 high");
    next_step("R9 high", 1'b0);
    first_step(QMIN + 10, QMIN, QMIN, "R9 low");
    next_step("R9 low", 1'b0);
    // random starts
    for (int r = 0; r < 20; r++) begin
      first_step(rnd_q(), rnd_q(), rnd_q(), "R6 random");
      for (int s = 0; s < 3; s++) next_step("R6 random", 1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule